// File: doc/BRIEF.md
# SPI DMA Byte Pacing and Interrupt Controller

This block sits next to an SPI shift engine that is fed one byte at a time by a DMA mover. It tracks how many bytes of the current transfer are still outstanding. As master, it decides when the mover may load the next byte, by holding a gap after each completed byte. It also drives a single sticky interrupt flag. The flag is set by a remaining-count watermark or by an optional time-out that runs after the most recent byte.

An 8-bit configuration word carries a 4-bit gap/time-out code in its upper nibble and a 4-bit watermark code in its lower nibble. As master, the gap is a fixed overhead plus the delay the code selects. The overhead depends on the SPI clock divider. When the delay-interrupt enable is set, the delay code instead times an interrupt, and the master gap shrinks to the overhead plus one. As slave, the block never paces. It only raises the time-out interrupt, and only when the enable is set. All delays count instruction-cycle enable pulses (`cyc_en`), not raw clocks.

The pins are plain control and status pins. The block has no data path, so there is no valid/ready pair. `load_next` is a one-cycle command with no back-pressure: the DMA side must take it in the cycle it appears.

Top module: `spi_dma_pacer`

## Requirements
- R1: After reset, `irq`, `load_next` and `remaining` are all zero.
- R2: A `xfer_start` pulse loads `xfer_len` into `remaining`. Each `byte_done` pulse seen while `remaining` is nonzero and `xfer_start` is low lowers it by one. A `byte_done` while `remaining` is zero is ignored.
- R3: As master (`slave_mode`=0) with `dly_irq_en`=0, an accepted byte that leaves `remaining` nonzero produces `load_next` after exactly G = base + delay `cyc_en` pulses. The pulses counted start at the edge after the accepting edge, so with `cyc_en` held high `load_next` is high in the G-th cycle after that edge. The base is 8, 9 and 15 for `clk_div_sel` = 00, 01 and 10, and 11 behaves as 10.
- R4: The delay code `ctrl_cfg[7:4]` maps as follows. Codes 0–7 give 2^code cycles. Codes 8–13 give (code−6)×128. Code 14 gives 1024 and code 15 gives 2048.
- R5: `load_next` is high for exactly one cycle per accepted byte. It never fires after the byte that takes `remaining` to zero.
- R6: As master with `dly_irq_en`=1, the gap G is base + 1, whatever the delay code.
- R7: With `dly_irq_en`=1, in either mode, `irq` becomes set one cycle after the delay count of `cyc_en` pulses has elapsed since the latest accepted byte. A newer accepted byte restarts that count.
- R8: As slave, `load_next` never fires. With `dly_irq_en`=0, no time-out interrupt occurs.
- R9: The watermark level is set by `ctrl_cfg[3:0]`. Code 0 gives 0, codes 1–6 give 2^(code−1), code 7 gives 67, and codes 8–15 give (code−6)×64. `irq` is set in the cycle after a `byte_done` that moves `remaining` onto the level. A `xfer_start` that loads the level directly does not set it, and staying at the level does not set it again.
- R10: `irq` stays set until a one-cycle `irq_clr`. A set event and a clear in the same cycle leave `irq` set.
- R11: The delay code, divider selection, mode and enable are sampled at the accepted byte. Changing them during a running gap does not alter that gap.
- R12: Cycles with `cyc_en` low do not advance any gap or time-out count.
- R13: `xfer_start` cancels any pending gap and time-out, so neither `load_next` nor a time-out interrupt follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cyc_en | input | 1 | Instruction-cycle enable pulse; counts delay |
| ctrl_cfg | input | 8 | [7:4] delay code, [3:0] watermark code |
| clk_div_sel | input | 2 | SPI clock divider: 00 /4, 01 /16, 10 or 11 /64 |
| slave_mode | input | 1 | 1 = slave, 0 = master |
| dly_irq_en | input | 1 | Delay code times an interrupt instead of the gap |
| xfer_start | input | 1 | Begin transfer, load byte count |
| xfer_len | input | REM_W | Total byte count of the transfer |
| byte_done | input | 1 | One-cycle pulse per completed byte |
| irq_clr | input | 1 | One-cycle clear of the interrupt flag |
| load_next | output | 1 | One-cycle strobe: load next byte |
| irq | output | 1 | Sticky interrupt flag |
| remaining | output | REM_W | Bytes still outstanding |

## Verification
The assertions assume that `byte_done`, `xfer_start` and `irq_clr` are single-cycle pulses. They also assume a new byte never completes while a master gap is still open, since a real shifter only starts after `load_next`. The directed stimulus keeps to these assumptions. It drives every input on the falling edge and keeps at least one clock between pulses. When several bytes are sent back to back, the test either waits out the gap or deliberately restarts it, checking that the restart rule applies. Configuration changes are made on purpose in the middle of a gap, to show that they are sampled only when a byte is accepted.

// File: rtl/spi_pace_pkg.sv
package spi_pace_pkg;

  typedef enum logic [1:0] {
    DIV_4     = 2'b00,
    DIV_16    = 2'b01,
    DIV_64    = 2'b10,
    DIV_64_ALT = 2'b11
  } clk_div_e;

  typedef struct packed {
    logic [3:0] dly_code;
    logic [3:0] wm_code;
  } pace_cfg_t;

  // Delay code to instruction cycles: doubling up to 128, then 128-steps,
  // then two large values.
  function automatic logic [11:0] dly_cycles(input logic [3:0] code);
    logic [11:0] r;
    if (code < 4'd8)
      r = 12'd1 << code;
    else if (code < 4'd14)
      r = {1'b0, 4'(code - 4'd6), 7'd0};
    else if (code == 4'd14)
      r = 12'd1024;
    else
      r = 12'd2048;
    return r;
  endfunction

  // Watermark code to remaining-byte level.
  function automatic logic [9:0] wm_level(input logic [3:0] code);
    logic [9:0] r;
    if (code == 4'd0)
      r = 10'd0;
    else if (code < 4'd7)
      r = 10'd1 << (code - 4'd1);
    else if (code == 4'd7)
      r = 10'd67;
    else
      r = {4'(code - 4'd6), 6'd0};
    return r;
  endfunction

endpackage

// File: rtl/cyc_countdown.sv
module cyc_countdown #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic             clear,
  input  logic             arm,
  input  logic [CNT_W-1:0] load_val,
  output logic             done,
  output logic             busy
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      busy <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (arm) begin
        busy <= 1'b1;
        cnt  <= load_val;
      end else if (clear) begin
        busy <= 1'b0;
        cnt  <= '0;
      end else if (busy && cyc_en) begin
        if (cnt == CNT_W'(1)) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
        cnt <= cnt - CNT_W'(1);
      end
    end
  end

  // R12: the count only moves on enabled cycles
  a_r12_hold_without_enable: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !cyc_en && !arm && !clear |=> $stable(cnt));

  // R5: expiry is a single-cycle event
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3: a countdown is never started at zero
  a_r3_load_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    arm |-> load_val != '0);

  // R13: a clear leaves the counter idle
  a_r13_clear_idles: assert property (@(posedge clk) disable iff (!rst_n)
    clear && !arm |=> !busy && !done);

endmodule

// File: rtl/byte_tracker.sv
module byte_tracker #(
  parameter int REM_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [REM_W-1:0] len,
  input  logic             byte_done,
  input  logic [REM_W-1:0] level,
  output logic [REM_W-1:0] remaining,
  output logic             accept,
  output logic             more,
  output logic             wm_pulse
);

  logic [REM_W-1:0] next_rem;

  always_comb begin
    accept   = byte_done && !start && (remaining != '0);
    next_rem = remaining - REM_W'(1);
    more     = remaining > REM_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remaining <= '0;
      wm_pulse  <= 1'b0;
    end else begin
      wm_pulse <= accept && (next_rem == level);
      if (start)
        remaining <= len;
      else if (accept)
        remaining <= next_rem;
    end
  end

  // R2: without a start the count never grows
  a_r2_no_growth: assert property (@(posedge clk) disable iff (!rst_n)
    !start |=> remaining <= $past(remaining));

  // R9: the watermark fires once per crossing
  a_r9_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
    wm_pulse |=> !wm_pulse);

endmodule

// File: rtl/irq_latch.sv
module irq_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq <= 1'b0;
    else
      irq <= (irq && !clr) || set;
  end

  // R10: a set event is never lost, even against a clear
  a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> irq);

  // R10: a lone clear drops the flag
  a_r10_clear_drops: assert property (@(posedge clk) disable iff (!rst_n)
    clr && !set |=> !irq);

  // R10: the flag is sticky without a clear
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !clr |=> irq);

endmodule

// File: rtl/spi_dma_pacer.sv
module spi_dma_pacer
  import spi_pace_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int REM_W      = 16,
  parameter int BASE_DIV4  = 8,
  parameter int BASE_DIV16 = 9,
  parameter int BASE_DIV64 = 15
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_en,
  input  logic [7:0]       ctrl_cfg,
  input  logic [1:0]       clk_div_sel,
  input  logic             slave_mode,
  input  logic             dly_irq_en,
  input  logic             xfer_start,
  input  logic [REM_W-1:0] xfer_len,
  input  logic             byte_done,
  input  logic             irq_clr,
  output logic             load_next,
  output logic             irq,
  output logic [REM_W-1:0] remaining
);

  pace_cfg_t        cfg;
  clk_div_e         div_sel;
  logic [CNT_W-1:0] base_gap;
  logic [CNT_W-1:0] dly_len;
  logic [CNT_W-1:0] pace_len;
  logic [REM_W-1:0] wm_lvl;
  logic             accept;
  logic             more;
  logic             wm_pulse;
  logic             arm_pace;
  logic             clr_pace;
  logic             arm_tmo;
  logic             clr_tmo;
  logic             tmo_done;
  logic             pace_busy;
  logic             tmo_busy;

  always_comb begin
    cfg     = pace_cfg_t'(ctrl_cfg);
    div_sel = clk_div_e'(clk_div_sel);
    unique case (div_sel)
      DIV_4:   base_gap = CNT_W'(BASE_DIV4);
      DIV_16:  base_gap = CNT_W'(BASE_DIV16);
      default: base_gap = CNT_W'(BASE_DIV64);
    endcase
    dly_len  = CNT_W'(dly_cycles(cfg.dly_code));
    pace_len = base_gap + (dly_irq_en ? CNT_W'(1) : dly_len);
    wm_lvl   = REM_W'(wm_level(cfg.wm_code));
    arm_pace = accept && more && !slave_mode;
    clr_pace = xfer_start || (accept && !arm_pace);
    arm_tmo  = accept && dly_irq_en;
    clr_tmo  = xfer_start || (accept && !dly_irq_en);
  end

  byte_tracker #(.REM_W(REM_W)) u_track (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (xfer_start),
    .len       (xfer_len),
    .byte_done (byte_done),
    .level     (wm_lvl),
    .remaining (remaining),
    .accept    (accept),
    .more      (more),
    .wm_pulse  (wm_pulse)
  );

  cyc_countdown #(.CNT_W(CNT_W)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .clear    (clr_pace),
    .arm      (arm_pace),
    .load_val (pace_len),
    .done     (load_next),
    .busy     (pace_busy)
  );

  cyc_countdown #(.CNT_W(CNT_W)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .cyc_en   (cyc_en),
    .clear    (clr_tmo),
    .arm      (arm_tmo),
    .load_val (dly_len),
    .done     (tmo_done),
    .busy     (tmo_busy)
  );

  irq_latch u_irq (
    .clk   (clk),
    .rst_n (rst_n),
    .set   (tmo_done || wm_pulse),
    .clr   (irq_clr),
    .irq   (irq)
  );

  // R5: a load strobe only appears while bytes are outstanding
  a_r5_load_has_bytes: assert property (@(posedge clk) disable iff (!rst_n)
    load_next |-> remaining != '0);

  // R8: a byte accepted as slave leaves no gap running
  a_r8_slave_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    accept && slave_mode |=> !pace_busy && !load_next);

  // R13: a start silences both countdowns
  a_r13_start_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_start |=> !load_next && !pace_busy && !tmo_busy);

endmodule

// File: tb/tb_spi_dma_pacer.sv
`timescale 1ns/1ps
module tb_spi_dma_pacer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cyc_en = 1'b1;
  logic [7:0]  ctrl_cfg = 8'h00;
  logic [1:0]  clk_div_sel = 2'b00;
  logic        slave_mode = 1'b0;
  logic        dly_irq_en = 1'b0;
  logic        xfer_start = 1'b0;
  logic [15:0] xfer_len = 16'd0;
  logic        byte_done = 1'b0;
  logic        irq_clr = 1'b0;
  logic        load_next;
  logic        irq;
  logic [15:0] remaining;

  int checks = 0;
  int errors = 0;
  bit gate = 1'b0;
  logic [1:0] phase = 2'd0;

  always #2.5 clk = ~clk;

  always @(negedge clk) begin
    phase <= phase + 2'd1;
    cyc_en <= gate ? (phase == 2'd0) : 1'b1;
  end

  spi_dma_pacer dut (
    .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .ctrl_cfg(ctrl_cfg),
    .clk_div_sel(clk_div_sel), .slave_mode(slave_mode), .dly_irq_en(dly_irq_en),
    .xfer_start(xfer_start), .xfer_len(xfer_len), .byte_done(byte_done),
    .irq_clr(irq_clr), .load_next(load_next), .irq(irq), .remaining(remaining)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic start_xfer(input int len);
    @(negedge clk); xfer_start = 1'b1; xfer_len = 16'(len);
    @(negedge clk); xfer_start = 1'b0;
  endtask

  task automatic pulse_byte();
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0;
  endtask

  task automatic clear_irq();
    @(negedge clk); irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
  endtask

  task automatic setup(input logic [3:0] dly, input logic [3:0] wm, input logic [1:0] div,
                       input logic slv, input logic en);
    @(negedge clk);
    ctrl_cfg = {dly, wm}; clk_div_sel = div; slave_mode = slv; dly_irq_en = en;
  endtask

  task automatic watch(input int limit, output int n_load, output int n_irq, output int loads);
    n_load = 0; n_irq = 0; loads = 0;
    for (int i = 1; i <= limit; i++) begin
      @(negedge clk);
      if (load_next) begin
        loads++;
        if (n_load == 0) n_load = i;
      end
      if (irq && n_irq == 0) n_irq = i;
    end
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq", int'(irq), 0);
    chk(load_next == 1'b0, "R1 load_next", int'(load_next), 0);
    chk(remaining == 16'd0, "R1 remaining", int'(remaining), 0);
  endtask

  // R3 R4 R5: master gap length per divider and delay code
  task automatic t_master_gap(input logic [1:0] div, input logic [3:0] code, input int exp_g);
    int nl, ni, nlo;
    setup(code, 4'd0, div, 1'b0, 1'b0);
    start_xfer(4);
    pulse_byte();
    chk(remaining == 16'd3, "R2 decrement", int'(remaining), 3);
    watch(exp_g + 4, nl, ni, nlo);
    chk(nl == exp_g, "R3 R4 gap length", nl, exp_g);
    chk(nlo == 1, "R5 single strobe", nlo, 1);
  endtask

  task automatic t_last_byte();
    int nl, ni, nlo;
    setup(4'd0, 4'd15, 2'b00, 1'b0, 1'b0);
    start_xfer(1);
    pulse_byte();
    watch(40, nl, ni, nlo);
    chk(nlo == 0, "R5 no strobe after last byte", nlo, 0);
    chk(remaining == 16'd0, "R2 reaches zero", int'(remaining), 0);
    pulse_byte();
    chk(remaining == 16'd0, "R2 ignore at zero", int'(remaining), 0);
    watch(20, nl, ni, nlo);
    chk(nlo == 0 && ni == 0, "R2 ignored byte has no effect", nlo + ni, 0);
  endtask

  task automatic t_dly_irq_master();
    int nl, ni, nlo;
    setup(4'd2, 4'd15, 2'b00, 1'b0, 1'b1);
    clear_irq();
    start_xfer(5);
    pulse_byte();
    watch(20, nl, ni, nlo);
    chk(nl == 9, "R6 shortened gap", nl, 9);
    chk(ni == 5, "R7 delay irq timing", ni, 5);
    clear_irq();
  endtask

  task automatic t_slave_timeout();
    int nl, ni, nlo;
    setup(4'd4, 4'd15, 2'b00, 1'b1, 1'b1);
    clear_irq();
    start_xfer(10);
    pulse_byte();
    watch(10, nl, ni, nlo);
    chk(ni == 0, "R7 no early timeout", ni, 0);
    pulse_byte();
    watch(25, nl, ni, nlo);
    chk(ni == 17, "R7 restart timeout", ni, 17);
    chk(nlo == 0, "R8 slave never loads", nlo, 0);
    clear_irq();
  endtask

  task automatic t_slave_quiet();
    int nl, ni, nlo;
    setup(4'd0, 4'd15, 2'b00, 1'b1, 1'b0);
    clear_irq();
    start_xfer(6);
    pulse_byte();
    watch(40, nl, ni, nlo);
    chk(ni == 0 && nlo == 0, "R8 slave without enable is silent", ni + nlo, 0);
  endtask

  task automatic t_watermark();
    setup(4'd0, 4'd7, 2'b00, 1'b0, 1'b0);
    clear_irq();
    start_xfer(69);
    pulse_byte();
    @(negedge clk);
    chk(irq == 1'b0, "R9 no hit at 68", int'(irq), 0);
    pulse_byte();
    chk(irq == 1'b0, "R9 irq not before next cycle", int'(irq), 0);
    @(negedge clk);
    chk(irq == 1'b1, "R9 hit at 67", int'(irq), 1);
    clear_irq();
    chk(irq == 1'b0, "R10 clear", int'(irq), 0);
    pulse_byte();
    @(negedge clk);
    chk(irq == 1'b0, "R9 transition only", int'(irq), 0);
    start_xfer(67);
    repeat (3) @(negedge clk);
    chk(irq == 1'b0, "R9 start at level no hit", int'(irq), 0);
    setup(4'd0, 4'd9, 2'b00, 1'b0, 1'b0);
    start_xfer(193);
    pulse_byte();
    @(negedge clk);
    chk(irq == 1'b1, "R9 level 192", int'(irq), 1);
    clear_irq();
    setup(4'd0, 4'd0, 2'b00, 1'b0, 1'b0);
    start_xfer(2);
    pulse_byte();
    @(negedge clk);
    chk(irq == 1'b0, "R9 complete not yet", int'(irq), 0);
    pulse_byte();
    @(negedge clk);
    chk(irq == 1'b1, "R9 complete level 0", int'(irq), 1);
    clear_irq();
  endtask

  task automatic t_irq_set_wins();
    setup(4'd0, 4'd1, 2'b00, 1'b0, 1'b0);
    clear_irq();
    start_xfer(2);
    pulse_byte();
    @(negedge clk);
    chk(irq == 1'b1, "R9 level 1", int'(irq), 1);
    setup(4'd0, 4'd0, 2'b00, 1'b0, 1'b0);
    @(negedge clk); byte_done = 1'b1;
    @(negedge clk); byte_done = 1'b0; irq_clr = 1'b1;
    @(negedge clk); irq_clr = 1'b0;
    chk(irq == 1'b1, "R10 set wins over clear", int'(irq), 1);
    repeat (20) @(negedge clk);
    chk(irq == 1'b1, "R10 sticky", int'(irq), 1);
    clear_irq();
    chk(irq == 1'b0, "R10 cleared", int'(irq), 0);
  endtask

  task automatic t_cfg_change();
    int nl, ni, nlo;
    setup(4'd8, 4'd15, 2'b00, 1'b0, 1'b0);
    start_xfer(4);
    pulse_byte();
    repeat (5) @(negedge clk);
    ctrl_cfg = 8'h0F; clk_div_sel = 2'b10; slave_mode = 1'b1; dly_irq_en = 1'b1;
    watch(270, nl, ni, nlo);
    chk(nl + 5 == 264, "R11 gap unaffected by change", nl + 5, 264);
    slave_mode = 1'b0; dly_irq_en = 1'b0;
  endtask

  task automatic t_gating();
    int nl, ni, nlo;
    setup(4'd0, 4'd15, 2'b00, 1'b0, 1'b0);
    gate = 1'b1;
    start_xfer(4);
    pulse_byte();
    watch(50, nl, ni, nlo);
    chk(nl >= 33 && nl <= 36, "R12 counts only enabled cycles", nl, 36);
    gate = 1'b0;
  endtask

  task automatic t_start_cancel();
    int nl, ni, nlo;
    setup(4'd3, 4'd15, 2'b00, 1'b0, 1'b1);
    clear_irq();
    setup(4'd3, 4'd15, 2'b00, 1'b0, 1'b0);
    start_xfer(5);
    dly_irq_en = 1'b1;
    pulse_byte();
    repeat (3) @(negedge clk);
    start_xfer(5);
    watch(40, nl, ni, nlo);
    chk(nlo == 0 && ni == 0, "R13 start cancels gap and timeout", nlo + ni, 0);
    chk(remaining == 16'd5, "R2 start reloads", int'(remaining), 5);
    dly_irq_en = 1'b0;
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_master_gap(2'b00, 4'd0, 9);
    t_master_gap(2'b01, 4'd3, 17);
    t_master_gap(2'b10, 4'd8, 271);
    t_master_gap(2'b11, 4'd13, 911);
    t_master_gap(2'b01, 4'd10, 521);
    t_master_gap(2'b00, 4'd14, 1032);
    t_master_gap(2'b00, 4'd15, 2056);
    t_last_byte();
    t_dly_irq_master();
    t_slave_timeout();
    t_slave_quiet();
    t_watermark();
    t_irq_set_wins();
    t_cfg_change();
    t_gating();
    t_start_cancel();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule